// File: doc/BRIEF.md
# UART DMA Request Pin Generator

This block drives the two active-low DMA request pins of a 16550-style serial port: one that asks a DMA engine to drain received characters and one that asks it to refill the transmitter. It observes the FIFO control settings (FIFO enable, DMA mode select, receive trigger select, receive and transmit clear strobes) and the occupancy reported by the surrounding receive and transmit paths. It also reports whether the receive FIFO has reached its programmed trigger level. The FIFO storage and the character timeout counter sit outside the block. It only sees their counts and a single-cycle timeout pulse.

Two signalling modes exist. In mode 0, and whenever the FIFOs are disabled, both pins simply follow occupancy: receive asks whenever anything is held, and transmit asks whenever nothing is held. In mode 1, with FIFOs enabled, the pins are latched. The receive pin is raised by the trigger level or a timeout and is held until the FIFO drains. The transmit pin is raised when the FIFO empties and is held until the FIFO is completely full. Both pins are registered, so each responds in the clock cycle after the inputs that cause it.

Top module: `uart_dma_req`

## Requirements
- R1: While reset is asserted and until the first input-driven update, rxrdy_no is 1 (inactive) and txrdy_no is 0 (active).
- R2: rx_trig_hit_o is 1 exactly when fifo_en_i is 1 and rx_count_i is at least the selected level. rx_trig_sel_i 00 selects 1, 01 selects 4, 10 selects 8 and 11 selects 14 (for depth 16). It is 0 whenever the FIFOs are disabled.
- R3: With fifo_en_i=0, or with fifo_en_i=1 and dma_mode_i=0, rxrdy_no is 0 in the cycle after at least one character is held and 1 otherwise. A held character means rx_count_i>0 in FIFO mode or rx_hold_full_i=1 in non-FIFO mode.
- R4: With fifo_en_i=1 and dma_mode_i=1, rxrdy_no goes to 0 in the cycle after rx_trig_hit_o or rx_timeout_i is seen with a non-empty FIFO. It then stays 0 while the FIFO is non-empty, goes to 1 in the cycle after rx_count_i=0, and otherwise holds its value.
- R5: With fifo_en_i=0, or with dma_mode_i=0, txrdy_no is 0 in the cycle after nothing is held and 1 otherwise. Nothing held means tx_count_i=0 in FIFO mode or tx_hold_full_i=0 in non-FIFO mode.
- R6: With fifo_en_i=1 and dma_mode_i=1, txrdy_no goes to 0 in the cycle after tx_count_i=0. It goes to 1 in the cycle after tx_full_i=1, and holds its value at any other fill level.
- R7: With fifo_en_i=1, rx_clr_i forces rxrdy_no to 1 and tx_clr_i forces txrdy_no to 0 in the next cycle, overriding every other condition and clearing the mode 1 latched state. With fifo_en_i=0 both strobes have no effect.
- R8: With fifo_en_i=0, dma_mode_i and rx_count_i have no effect on either pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | FIFO enable control bit |
| dma_mode_i | input | 1 | DMA signalling mode select (1 = mode 1) |
| rx_trig_sel_i | input | 2 | Receive trigger level select |
| rx_clr_i | input | 1 | Receive FIFO clear strobe |
| tx_clr_i | input | 1 | Transmit FIFO clear strobe |
| rx_count_i | input | 5 | Receive FIFO occupancy |
| rx_timeout_i | input | 1 | Receive character timeout pulse |
| rx_hold_full_i | input | 1 | Receive holding register occupied (non-FIFO mode) |
| tx_count_i | input | 5 | Transmit FIFO occupancy |
| tx_full_i | input | 1 | Transmit FIFO full flag |
| tx_hold_full_i | input | 1 | Transmit holding register occupied (non-FIFO mode) |
| rxrdy_no | output | 1 | Receive DMA request, active low |
| txrdy_no | output | 1 | Transmit DMA request, active low |
| rx_trig_hit_o | output | 1 | Receive trigger level reached |

## Verification
The bound checker watches the per-cycle rules on every cycle: an empty receive FIFO drops the receive request, a trigger or timeout with data raises it in mode 1, the transmit request holds steady at partial fill in mode 1, and the clear strobes take effect. Other behaviour only shows up in the bench's ordered scenarios. These are the hysteresis on both pins across fill and drain sequences, the exact threshold for each trigger select, and the fact that clears and the mode bit are ignored while the FIFOs are disabled. The bench drives them against a reference model built from the requirements.

// File: rtl/uart_dma_req_pkg.sv
package uart_dma_req_pkg;

  // Receive trigger threshold for a FIFO of the given depth.
  function automatic int trig_level(input logic [1:0] sel, input int depth);
    case (sel)
      2'b00:   return 1;
      2'b01:   return depth / 4;
      2'b10:   return depth / 2;
      default: return depth - 2;
    endcase
  endfunction

endpackage

// File: rtl/uart_dma_trig.sv
module uart_dma_trig #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             fifo_en_i,
  input  logic [1:0]       sel_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             hit_o
);
  import uart_dma_req_pkg::*;

  logic [CNT_W-1:0] level;

  assign level = CNT_W'(trig_level(sel_i, DEPTH));
  assign hit_o = fifo_en_i && (count_i >= level);

endmodule

// File: rtl/uart_dma_rx_req.sv
module uart_dma_rx_req #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             latch_mode_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             hold_full_i,
  input  logic             trig_hit_i,
  input  logic             timeout_i,
  output logic             req_o
);
  logic occ;
  logic req_d, req_q;

  assign occ = fifo_en_i ? (count_i != '0) : hold_full_i;

  always_comb begin
    req_d = req_q;
    if (fifo_en_i && clr_i)      req_d = 1'b0;
    else if (latch_mode_i) begin
      if (!occ)                  req_d = 1'b0;
      else if (trig_hit_i || timeout_i) req_d = 1'b1;
    end else                     req_d = occ;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= req_d;
  end

  assign req_o = req_q;

endmodule

// File: rtl/uart_dma_tx_req.sv
module uart_dma_tx_req #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             latch_mode_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             full_i,
  input  logic             hold_full_i,
  output logic             req_o
);
  logic occ;
  logic req_d, req_q;

  assign occ = fifo_en_i ? (count_i != '0) : hold_full_i;

  always_comb begin
    req_d = req_q;
    if (fifo_en_i && clr_i)      req_d = 1'b1;
    else if (latch_mode_i) begin
      // set on empty, release only on completely full
      if (!occ)                  req_d = 1'b1;
      else if (full_i)           req_d = 1'b0;
    end else                     req_d = !occ;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b1;
    else         req_q <= req_d;
  end

  assign req_o = req_q;

endmodule

// File: rtl/uart_dma_req.sv
module uart_dma_req #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             dma_mode_i,
  input  logic [1:0]       rx_trig_sel_i,
  input  logic             rx_clr_i,
  input  logic             tx_clr_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic             rx_timeout_i,
  input  logic             rx_hold_full_i,
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic             tx_full_i,
  input  logic             tx_hold_full_i,
  output logic             rxrdy_no,
  output logic             txrdy_no,
  output logic             rx_trig_hit_o
);
  logic latch_mode;
  logic trig_hit;
  logic rx_req, tx_req;

  assign latch_mode = fifo_en_i && dma_mode_i;

  uart_dma_trig #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_trig (
    .fifo_en_i (fifo_en_i),
    .sel_i     (rx_trig_sel_i),
    .count_i   (rx_count_i),
    .hit_o     (trig_hit)
  );

  uart_dma_rx_req #(.CNT_W(CNT_W)) u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fifo_en_i    (fifo_en_i),
    .latch_mode_i (latch_mode),
    .clr_i        (rx_clr_i),
    .count_i      (rx_count_i),
    .hold_full_i  (rx_hold_full_i),
    .trig_hit_i   (trig_hit),
    .timeout_i    (rx_timeout_i),
    .req_o        (rx_req)
  );

  uart_dma_tx_req #(.CNT_W(CNT_W)) u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fifo_en_i    (fifo_en_i),
    .latch_mode_i (latch_mode),
    .clr_i        (tx_clr_i),
    .count_i      (tx_count_i),
    .full_i       (tx_full_i),
    .hold_full_i  (tx_hold_full_i),
    .req_o        (tx_req)
  );

  assign rxrdy_no      = !rx_req;
  assign txrdy_no      = !tx_req;
  assign rx_trig_hit_o = trig_hit;

endmodule

// File: rtl/uart_dma_req_chk.sv
module uart_dma_req_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fifo_en_i,
  input logic             dma_mode_i,
  input logic             rx_clr_i,
  input logic             tx_clr_i,
  input logic [CNT_W-1:0] rx_count_i,
  input logic             rx_timeout_i,
  input logic [CNT_W-1:0] tx_count_i,
  input logic             tx_full_i,
  input logic             tx_hold_full_i,
  input logic             rxrdy_no,
  input logic             txrdy_no,
  input logic             rx_trig_hit_o
);

  // R3 / R4: empty receive FIFO always drops the request
  assert_rx_empty_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en_i && rx_count_i == '0) |=> rxrdy_no);

  assert_rx_trig_raise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en_i && dma_mode_i && !rx_clr_i && rx_count_i != '0 &&
     (rx_trig_hit_o || rx_timeout_i)) |=> !rxrdy_no);

  assert_tx_partial_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en_i && dma_mode_i && !tx_clr_i && tx_count_i != '0 && !tx_full_i)
      |=> $stable(txrdy_no));

  assert_tx_full_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en_i && dma_mode_i && !tx_clr_i && tx_count_i != '0 && tx_full_i) |=> txrdy_no);

  assert_tx_nofifo_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en_i && !tx_hold_full_i) |=> !txrdy_no);

  assert_tx_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en_i && tx_clr_i) |=> !txrdy_no);

  assert_trig_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i |-> !rx_trig_hit_o);

endmodule

bind uart_dma_req uart_dma_req_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .fifo_en_i      (fifo_en_i),
  .dma_mode_i     (dma_mode_i),
  .rx_clr_i       (rx_clr_i),
  .tx_clr_i       (tx_clr_i),
  .rx_count_i     (rx_count_i),
  .rx_timeout_i   (rx_timeout_i),
  .tx_count_i     (tx_count_i),
  .tx_full_i      (tx_full_i),
  .tx_hold_full_i (tx_hold_full_i),
  .rxrdy_no       (rxrdy_no),
  .txrdy_no       (txrdy_no),
  .rx_trig_hit_o  (rx_trig_hit_o)
);

// File: tb/tb_uart_dma_req.sv
module tb_uart_dma_req;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             fifo_en_i = 1'b0, dma_mode_i = 1'b0;
  logic [1:0]       rx_trig_sel_i = 2'b00;
  logic             rx_clr_i = 1'b0, tx_clr_i = 1'b0;
  logic [CNT_W-1:0] rx_count_i = '0, tx_count_i = '0;
  logic             rx_timeout_i = 1'b0, rx_hold_full_i = 1'b0;
  logic             tx_full_i = 1'b0, tx_hold_full_i = 1'b0;
  logic             rxrdy_no, txrdy_no, rx_trig_hit_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic  rx_n;
    logic  tx_n;
    logic  trig;
    string tag;
  } exp_t;

  exp_t q[$];

  // reference state (active-high requests)
  logic m_rx = 1'b0;
  logic m_tx = 1'b1;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  uart_dma_req #(.DEPTH(DEPTH)) dut (
    .clk_i, .rst_ni, .fifo_en_i, .dma_mode_i, .rx_trig_sel_i,
    .rx_clr_i, .tx_clr_i, .rx_count_i, .rx_timeout_i, .rx_hold_full_i,
    .tx_count_i, .tx_full_i, .tx_hold_full_i,
    .rxrdy_no, .txrdy_no, .rx_trig_hit_o
  );

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  function automatic int lvl(input logic [1:0] s);
    case (s)
      2'b00: return 1;
      2'b01: return 4;
      2'b10: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic step(input logic fe, input logic dm, input logic [1:0] sel,
                      input logic rclr, input logic tclr, input int rcnt,
                      input logic tmo, input logic rhr, input int tcnt,
                      input logic thr, input string tag);
    exp_t e;
    logic trig, occ;
    @(negedge clk_i);
    fifo_en_i = fe; dma_mode_i = dm; rx_trig_sel_i = sel;
    rx_clr_i = rclr; tx_clr_i = tclr; rx_count_i = CNT_W'(rcnt);
    rx_timeout_i = tmo; rx_hold_full_i = rhr; tx_count_i = CNT_W'(tcnt);
    tx_full_i = (tcnt == DEPTH); tx_hold_full_i = thr;
    trig = fe && (rcnt >= lvl(sel));
    occ = fe ? (rcnt != 0) : rhr;
    if (fe && rclr) m_rx = 1'b0;
    else if (fe && dm) begin
      if (!occ) m_rx = 1'b0;
      else if (trig || tmo) m_rx = 1'b1;
    end else m_rx = occ;
    occ = fe ? (tcnt != 0) : thr;
    if (fe && tclr) m_tx = 1'b1;
    else if (fe && dm) begin
      if (!occ) m_tx = 1'b1;
      else if (tcnt == DEPTH) m_tx = 1'b0;
    end else m_tx = !occ;
    e.rx_n = !m_rx; e.tx_n = !m_tx; e.trig = trig; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: sample one time unit after the edge that registers the step
  always @(posedge clk_i) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(rxrdy_no, e.rx_n, {e.tag, " rxrdy_no"});
      check(txrdy_no, e.tx_n, {e.tag, " txrdy_no"});
      check(rx_trig_hit_o, e.trig, {e.tag, " rx_trig_hit_o"});
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 3);
    check(rxrdy_no, 1'b1, "R1 reset rxrdy_no");
    check(txrdy_no, 1'b0, "R1 reset txrdy_no");
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check(rxrdy_no, 1'b1, "R1 after release rxrdy_no");
    check(txrdy_no, 1'b0, "R1 after release txrdy_no");

    // non-FIFO: holding registers drive the pins (R3, R5, R8)
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 1, "R3 R5 nofifo held");
    step(0, 1, 3, 0, 0, 15, 0, 0, 0, 0, "R8 R2 nofifo mode bit ignored");
    step(0, 1, 0, 1, 0, 5, 0, 1, 0, 0, "R7 R8 clear ignored without fifo");
    step(0, 0, 0, 0, 1, 0, 0, 1, 0, 1, "R7 tx clear ignored without fifo");

    // FIFO mode 0
    step(1, 0, 3, 0, 0, 1, 0, 0, 3, 0, "R3 R5 mode0 occupied");
    step(1, 0, 3, 0, 0, 0, 0, 1, 0, 1, "R3 R5 mode0 empty");

    // mode 1 receive, thresholds (R2, R4)
    step(1, 1, 1, 0, 0, 3, 0, 0, 0, 0, "R2 R4 sel01 below");
    step(1, 1, 1, 0, 0, 4, 0, 0, 0, 0, "R2 R4 sel01 reached");
    step(1, 1, 1, 0, 0, 2, 0, 0, 0, 0, "R4 hold while draining");
    step(1, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R4 release on empty");
    step(1, 1, 1, 0, 0, 2, 1, 0, 0, 0, "R4 timeout raise");
    step(1, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R4 empty after timeout");
    step(1, 1, 2, 0, 0, 7, 0, 0, 0, 0, "R2 sel10 below");
    step(1, 1, 2, 0, 0, 8, 0, 0, 0, 0, "R2 sel10 reached");
    step(1, 1, 3, 0, 0, 0, 0, 0, 0, 0, "R4 drain");
    step(1, 1, 3, 0, 0, 13, 0, 0, 0, 0, "R2 sel11 below");
    step(1, 1, 3, 0, 0, 14, 0, 0, 0, 0, "R2 sel11 reached");
    step(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R4 drain again");
    step(1, 1, 0, 0, 0, 1, 0, 0, 0, 0, "R2 sel00 one byte");

    // mode 1 transmit hysteresis (R6)
    step(1, 1, 0, 0, 0, 1, 0, 0, 0, 0, "R6 tx empty");
    step(1, 1, 0, 0, 0, 1, 0, 0, 5, 0, "R6 tx partial keeps request");
    step(1, 1, 0, 0, 0, 1, 0, 0, 16, 0, "R6 tx full release");
    step(1, 1, 0, 0, 0, 1, 0, 0, 10, 0, "R6 tx partial stays released");
    step(1, 1, 0, 0, 0, 1, 0, 0, 0, 0, "R6 tx empty again");

    // clears in FIFO mode (R7)
    step(1, 1, 0, 0, 0, 1, 0, 0, 16, 0, "R7 setup full");
    step(1, 1, 0, 1, 1, 1, 0, 0, 12, 0, "R7 clears override");
    step(1, 1, 0, 0, 0, 0, 0, 0, 12, 0, "R7 R6 tx held after clear");
    step(1, 1, 2, 0, 0, 5, 0, 0, 12, 0, "R7 R4 rx not relatched below level");

    @(negedge clk_i);
    @(negedge clk_i);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule